// File: doc/BRIEF.md
# SAR converter strobe and output-bus controller

This block is the clocked digital shell of a 12-bit successive-approximation converter as seen from its pins. Two active-low style strobes, a chip select and a read/convert line, are OR-combined internally. A falling edge of that combination while read/convert is low starts a conversion. A low chip select together with a high read/convert opens the output bus. The conversion engine is modelled as a countdown of `CONV_CYCLES` clocks. The word on `sample_word` is frozen at the start edge and copied into the output register when the count ends.

The active-low busy flag is low for the whole conversion. The output register keeps its last value until the next conversion completes. The output bus has 16 lines in two lanes of eight. Data lines are always driven with the formatted result, and `bus_oe` marks when the pins would leave high impedance. Four of the lines are forced to zero, and a byte-select input swaps the two lanes.

The strobes are taken as synchronous to `clk`. Edges are detected against the values held at the previous clock.

Top module: `sar_adc_frontend`

## Requirements
- R1: With `cs_n` low, a clock at which `rd_conv` is seen low after being high at the previous clock starts a conversion, and `busy_n` is low after that clock.
- R2: With `rd_conv` low, a clock at which `cs_n` is seen low after being high starts a conversion in the same way.
- R3: A falling `cs_n` while `rd_conv` is high, or a rising `rd_conv` while `cs_n` is low, starts no conversion (`busy_n` stays high) and opens the bus.
- R4: `bus_oe` is 1 exactly when `cs_n` is 0 and `rd_conv` is 1, combinationally; otherwise it is 0 (all lines high impedance).
- R5: `busy_n` stays low for exactly `CONV_CYCLES` clocks and then rises. At that same clock the output register takes the `sample_word` value seen at the start clock.
- R6: A start condition seen while `busy_n` is low is ignored. It neither extends the conversion nor re-captures `sample_word`.
- R7: If `cs_n` and `rd_conv` are both low at the clock after `busy_n` rises, a new conversion starts at that clock. `busy_n` is therefore high for one cycle only, and the new sample is captured.
- R8: With `byte_sel` = 0, `bus_data[15:8]` = result[11:4], `bus_data[7:4]` = result[3:0] and `bus_data[3:0]` = 0 (bit 15 is the first pin of the upper lane).
- R9: With `byte_sel` = 1, `bus_data[15:12]` = result[3:0], `bus_data[11:8]` = 0 and `bus_data[7:0]` = result[11:4] (bit 7 carries the MSB).
- R10: After reset `busy_n` = 1, `bus_oe` follows R4 and the output register is zero. The register changes only at the clock where `busy_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | High = read, low = convert |
| byte_sel | input | 1 | 1 swaps the upper and lower lanes |
| sample_word | input | 12 | Word the modelled engine converts |
| busy_n | output | 1 | Low while a conversion runs |
| bus_data | output | 16 | Formatted result, two lanes of eight |
| bus_oe | output | 1 | 1 when the bus pins drive, 0 for high impedance |

## Verification
The hardest case to reach is the back-to-back restart. Both strobes must be low on exactly the clock that follows the rise of `busy_n`, while the sample input has moved since the first start. The stimulus holds both strobes low through a whole conversion and changes `sample_word` halfway through. It then checks that `busy_n` is high for one cycle only and that the second result is the new word. A long random phase with strobes that toggle slowly lets starts, ignored starts during busy and restarts line up at the completion clock by chance. A behavioural model compares every clock against these outcomes.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

   typedef enum logic [0:0] {
      ORDER_NORMAL  = 1'b0,
      ORDER_SWAPPED = 1'b1
   } lane_order_e;

endpackage

// File: rtl/sar_strobe_decode.sv
module sar_strobe_decode (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic rd_conv,
   input  logic conv_idle,
   input  logic conv_finished,
   output logic start_req,
   output logic read_en
);

   logic strobe_q;
   logic strobe_now;
   logic strobe_fall;

   assign strobe_now = cs_n | rd_conv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b1;
      else        strobe_q <= strobe_now;
   end

   assign strobe_fall = strobe_q & ~strobe_now;

   // a fresh edge, or both strobes still low right after completion
   assign start_req = conv_idle & ~rd_conv & (strobe_fall | (conv_finished & ~cs_n));
   assign read_en   = ~cs_n & rd_conv;

endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
   parameter int CONV_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   output logic busy,
   output logic finish,
   output logic finished_q
);

   localparam int CNT_W = $clog2(CONV_CYCLES + 1);

   logic             busy_q;
   logic [CNT_W-1:0] left_q;

   assign finish = busy_q && (left_q == '0);
   assign busy   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         left_q     <= '0;
         finished_q <= 1'b0;
      end else begin
         finished_q <= finish;
         if (!busy_q && start_req) begin
            busy_q <= 1'b1;
            left_q <= CNT_W'(CONV_CYCLES - 1);
         end else if (finish) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   // run-length checker, independent of left_q
   logic [CNT_W:0] chk_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chk_run <= '0;
      else if (busy_q) chk_run <= chk_run + 1'b1;
      else             chk_run <= '0;
   end

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy_q) |=> busy_q);                                 // R1
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (chk_run < CONV_CYCLES - 1)) |=> busy_q);                // R6
   AST_CONV_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (chk_run < CONV_CYCLES));                                // R5
   AST_CONV_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (chk_run == CONV_CYCLES));                        // R5

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              commit,
   input  logic [DATA_W-1:0] sample_in,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         result <= '0;
      end else begin
         if (capture) hold_q <= sample_in;
         if (commit)  result <= hold_q;
      end
   end

endmodule

// File: rtl/sar_bus_format.sv
module sar_bus_format
   import adc_fe_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int LANE_W  = 8,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic                byte_sel,
   input  logic [DATA_W-1:0]   word,
   output logic [2*LANE_W-1:0] lanes
);

   localparam int LO_W  = DATA_W - LANE_W;
   localparam int PAD_W = LANE_W - LO_W;

   lane_order_e       order;
   logic [LANE_W-1:0] upper_part;
   logic [LO_W-1:0]   lower_part;

   assign upper_part = word[DATA_W-1 -: LANE_W];
   assign lower_part = word[LO_W-1:0];

   generate
      if (SWAP_EN) begin : g_swap
         assign order = byte_sel ? ORDER_SWAPPED : ORDER_NORMAL;
      end else begin : g_fixed
         logic unused_sel;
         assign unused_sel = byte_sel;
         assign order      = ORDER_NORMAL;
      end
   endgenerate

   always_comb begin
      case (order)
         ORDER_SWAPPED: lanes = {lower_part, {PAD_W{1'b0}}, upper_part};
         default:       lanes = {upper_part, lower_part, {PAD_W{1'b0}}};
      endcase
   end

endmodule

// File: rtl/sar_adc_frontend.sv
module sar_adc_frontend #(
   parameter int DATA_W      = 12,
   parameter int LANE_W      = 8,
   parameter int CONV_CYCLES = 16,
   parameter bit SWAP_EN     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                rd_conv,
   input  logic                byte_sel,
   input  logic [DATA_W-1:0]   sample_word,
   output logic                busy_n,
   output logic [2*LANE_W-1:0] bus_data,
   output logic                bus_oe
);

   generate
      if (DATA_W <= LANE_W || DATA_W > 2 * LANE_W) begin : g_bad_width
         $error("DATA_W must lie between LANE_W+1 and 2*LANE_W");
      end
      if (CONV_CYCLES < 2) begin : g_bad_cycles
         $error("CONV_CYCLES must be at least 2");
      end
   endgenerate

   logic              start_req;
   logic              busy;
   logic              finish;
   logic              finished_q;
   logic [DATA_W-1:0] result_w;

   sar_strobe_decode u_decode (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_n          (cs_n),
      .rd_conv       (rd_conv),
      .conv_idle     (~busy),
      .conv_finished (finished_q),
      .start_req     (start_req),
      .read_en       (bus_oe)
   );

   sar_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .busy       (busy),
      .finish     (finish),
      .finished_q (finished_q)
   );

   sar_result_reg #(.DATA_W(DATA_W)) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (start_req),
      .commit    (finish),
      .sample_in (sample_word),
      .result    (result_w)
   );

   sar_bus_format #(.DATA_W(DATA_W), .LANE_W(LANE_W), .SWAP_EN(SWAP_EN)) u_format (
      .byte_sel (byte_sel),
      .word     (result_w),
      .lanes    (bus_data)
   );

   assign busy_n = ~busy;

   AST_RESULT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_w) |-> $rose(busy_n));                              // R10
   AST_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_n) && !cs_n && !rd_conv) |=> !busy_n);                  // R7
   AST_NO_START_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_n && rd_conv) |=> busy_n);                                    // R3

endmodule

// File: tb/sim_sar_adc_frontend.sv
module sim_sar_adc_frontend;

   localparam int CONV = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_conv = 1'b1;
   logic        byte_sel = 1'b0;
   logic [11:0] sample_word = '0;
   logic        busy_n;
   logic [15:0] bus_data;
   logic        bus_oe;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   sar_adc_frontend #(.CONV_CYCLES(CONV)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_conv(rd_conv),
      .byte_sel(byte_sel), .sample_word(sample_word),
      .busy_n(busy_n), .bus_data(bus_data), .bus_oe(bus_oe)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] fmt(input logic [11:0] d, input logic sw);
      return sw ? {d[3:0], 4'h0, d[11:4]} : {d[11:4], d[3:0], 4'h0};
   endfunction

   // behavioural reference model
   bit          m_prev = 1'b1;
   bit          m_busy = 1'b0;
   bit          m_just = 1'b0;
   int          m_left = 0;
   logic [11:0] m_hold = '0;
   logic [11:0] m_result = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prev = 1'b1; m_busy = 1'b0; m_just = 1'b0;
         m_left = 0; m_hold = '0; m_result = '0;
      end else begin
         bit eff, fall, start, nj;
         eff   = cs_n | rd_conv;
         fall  = m_prev && !eff && !rd_conv;
         start = !m_busy && (fall || (m_just && !cs_n && !rd_conv));
         nj    = 1'b0;
         if (m_busy) begin
            if (m_left == 1) begin
               m_busy = 1'b0; m_result = m_hold; nj = 1'b1;
            end else m_left--;
         end else if (start) begin
            m_busy = 1'b1; m_left = CONV; m_hold = sample_word;
         end
         m_just = nj;
         m_prev = eff;
      end
   end

   always @(negedge clk) begin
      #2;
      if (rst_n && !ended) begin
         chk("R5 busy_n vs model", busy_n, !m_busy);
         chk("R4 bus_oe vs model", bus_oe, (!cs_n && rd_conv));
         if (bus_oe) begin
            if (byte_sel) chk("R9 swapped bus", bus_data, fmt(m_result, 1'b1));
            else          chk("R8 normal bus", bus_data, fmt(m_result, 1'b0));
         end
      end
   end

   task automatic step(input logic c, input logic r);
      @(negedge clk);
      cs_n = c; rd_conv = r;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4 * CONV; i++) begin
         @(negedge clk); #1;
         if (busy_n) break;
      end
   endtask

   task automatic finish_run();
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R10 reset busy_n", busy_n, 1);
      chk("R10 reset bus_oe", bus_oe, 0);
      rst_n = 1'b1;

      // R3: cs falls with rd_conv high -> bus opens, no conversion
      step(1'b0, 1'b1); #1;
      chk("R3 bus opens on cs fall", bus_oe, 1);
      chk("R10 reset result is zero", bus_data, 0);
      @(negedge clk); #1;
      chk("R3 no start on read", busy_n, 1);

      // R1: rd_conv falls while cs low
      sample_word = 12'hA5C;
      step(1'b0, 1'b0);
      @(negedge clk); #1;
      chk("R1 start on rd_conv fall", busy_n, 0);
      chk("R4 bus closed while converting", bus_oe, 0);
      step(1'b0, 1'b1);
      wait_idle();
      chk("R5 result after conversion", bus_data, fmt(12'hA5C, 1'b0));

      // R2: cs falls while rd_conv low
      step(1'b1, 1'b0);
      sample_word = 12'h3C7;
      step(1'b0, 1'b0);
      @(negedge clk); #1;
      chk("R2 start on cs fall", busy_n, 0);
      // R6: new start attempt during busy
      step(1'b1, 1'b0);
      sample_word = 12'h0FF;
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      wait_idle();
      #1;
      chk("R6 ignored start keeps first sample", bus_data, fmt(12'h3C7, 1'b0));
      @(negedge clk); #1;
      chk("R6 no extra conversion", busy_n, 1);

      // R8 / R9 lane order
      byte_sel = 1'b1; #1;
      chk("R9 swapped lanes", bus_data, fmt(12'h3C7, 1'b1));
      byte_sel = 1'b0; #1;
      chk("R8 normal lanes", bus_data, fmt(12'h3C7, 1'b0));

      // R7: both low held across completion
      sample_word = 12'h111;
      step(1'b0, 1'b0);
      repeat (CONV / 2) @(negedge clk);
      sample_word = 12'h222;
      wait_idle();
      chk("R7 busy rises", busy_n, 1);
      @(negedge clk); #1;
      chk("R7 immediate restart", busy_n, 0);
      step(1'b0, 1'b1);
      wait_idle();
      #1;
      chk("R7 restart captured new sample", bus_data, fmt(12'h222, 1'b0));

      // random phase, checked against the model every clock
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 3) == 0) cs_n = $urandom_range(0, 1);
         if ($urandom_range(0, 3) == 0) rd_conv = $urandom_range(0, 1);
         if ($urandom_range(0, 7) == 0) byte_sel = $urandom_range(0, 1);
         sample_word = 12'($urandom);
      end
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule